// File: doc/BRIEF.md
# Sync-Locked Pixel Strobe Regenerator

This block recreates a capture strobe at pixel rate from two inputs: a horizontal sync pulse and an oversampling clock that runs at six or eight times the pixel rate. A modulo-6 or modulo-8 phase counter restarts on each rising edge of sync. Every cycle in which the counter equals a programmable phase value is one pixel slot, so moving that value shifts the sampling point across a whole pixel period relative to sync. A receiver samples on both edges of the strobe, so the strobe changes level once per bus transfer.

A line sequencer handles each line. It discards a fixed number of pixel slots after sync, during which the counter keeps running, and then a further 0 to 3 slots of fine horizontal shift. After that it passes pixels to a packer. The packer places one 12-bit pixel, two 6-bit pixels or four 3-bit pixels into each 12-bit bus word. Each new word appears on the bus one oversampling clock before the strobe edge that announces it, which gives the receiver setup margin. The phase value, the ratio, the pixel depth and the fine shift are all captured at the sync edge, so a change made partway through a line applies from the next line.

Line sequencer states:
- ST_IDLE: entered from reset; waits for the first sync edge.
- ST_HOLD: suppression window.
- ST_SHIFT: fine-shift skip.
- ST_RUN: packing.

Transitions:
- Any state goes to ST_HOLD on a sync edge.
- ST_HOLD goes to ST_SHIFT after the last suppressed slot when the shift is non-zero, or to ST_RUN when it is zero.
- ST_SHIFT goes to ST_RUN after the last skipped slot.
- ST_RUN stays in ST_RUN until the next sync edge.

Top module: `hsync_strobe_regen`

## Requirements
- R1: After reset `strobe` and `data_out` are 0. No strobe edge occurs before the first rising edge of `hsync`, whatever `pix_in` does.
- R2: A rising edge of `hsync` at clock edge S restarts the phase counter. With t counting clock edges after S, the cycle t is a pixel slot when t mod N equals the active phase value. N is 6 when `ratio_x8`=0 and 8 when it is 1. No slot occurs in the cycle whose closing edge carries a sync edge.
- R3: A write on `ofs_we`/`ofs_wdata` becomes active at the next sync edge. `ratio_x8`, `depth_sel` and `fine_shift` are likewise captured at the sync edge. A phase value of N or more never matches, so that line has no strobe edges.
- R4: The first SUPP_PIX slots (default 2) after each sync edge are discarded.
- R5: After the suppressed slots, a further `fine_shift` slots (0 to 3) are discarded before packing starts.
- R6: Depth code 0 sends `pix_in[11:0]` as one pixel per word. Code 1 takes `pix_in[5:0]` for two pixels per word, the first in bits [5:0] and the second in [11:6]. Codes 2 and 3 take `pix_in[2:0]` for four pixels per word, with pixel k in bits [3k+2:3k].
- R7: The slot that completes a word updates `data_out` at its closing clock edge, and `strobe` inverts at the following edge. `strobe` changes at no other time.
- R8: A sync edge discards a partly filled word. The next line starts a fresh word at pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 6x or 8x pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync, rising edge active |
| ratio_x8 | input | 1 | 0: 6 clocks per pixel, 1: 8 clocks per pixel |
| ofs_we | input | 1 | Write strobe for the phase value |
| ofs_wdata | input | 3 | Phase value to write |
| depth_sel | input | 2 | Pixel depth code (0: 12, 1: 6, 2/3: 3 bits) |
| fine_shift | input | 2 | Extra pixel slots skipped per line |
| pix_in | input | 12 | Incoming pixel value |
| strobe | output | 1 | Regenerated transfer strobe, one edge per word |
| data_out | output | 12 | Packed bus word |

## Verification
A table of line settings is used, and each setting differs in the ratio, the phase value, the depth and the shift together. The first strobe edge of each line lands at a cycle fixed by hand, so that single number tells apart errors in the counter length, the phase compare, the suppression count and the shift count. A pixel value that changes every cycle shows whether the right slot is sampled and placed in the right field. Each word is checked one cycle before its strobe edge and again at it. A line ending in a half-filled word, followed by a 6-bit line, shows whether leftover pixels survive across sync. A line whose phase value cannot match, mid-line setting writes, and a reset followed by no sync cover the quiet cases.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
    localparam int BUS_W = 12;
    localparam int CNT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_RUN   = 2'd3
    } line_state_t;

    localparam logic [1:0] DEPTH_12 = 2'd0;
    localparam logic [1:0] DEPTH_6  = 2'd1;

    function automatic logic [1:0] last_slot(input logic [1:0] depth);
        if (depth == DEPTH_12)     return 2'd0;
        else if (depth == DEPTH_6) return 2'd1;
        else                       return 2'd3;
    endfunction
endpackage

// File: rtl/hsr_phase_counter.sv
module hsr_phase_counter
    import hsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic             ratio_x8,
    input  logic             ofs_we,
    input  logic [CNT_W-1:0] ofs_wdata,
    output logic             sync_edge,
    output logic             pix_evt
);
    localparam logic [CNT_W-1:0] LAST_X6 = CNT_W'(5);
    localparam logic [CNT_W-1:0] LAST_X8 = CNT_W'(7);

    logic             hs_q;
    logic             ratio_q;
    logic [CNT_W-1:0] ofs_pend_q;
    logic [CNT_W-1:0] ofs_act_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign sync_edge = hsync & ~hs_q;
    assign last      = ratio_q ? LAST_X8 : LAST_X6;
    assign pix_evt   = (cnt_q == ofs_act_q) & ~sync_edge;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q       <= 1'b0;
            ratio_q    <= 1'b0;
            ofs_pend_q <= '0;
            ofs_act_q  <= '0;
            cnt_q      <= '0;
        end else begin
            hs_q <= hsync;
            if (ofs_we) ofs_pend_q <= ofs_wdata;
            if (sync_edge) begin
                cnt_q     <= '0;
                ofs_act_q <= ofs_pend_q;
                ratio_q   <= ratio_x8;
            end else if (cnt_q == last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // R2: counter never leaves its modulo range
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last);
    // R2: sync edge restarts the count
    a_r2_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sync_edge |=> (cnt_q == '0));
endmodule

// File: rtl/hsr_line_fsm.sv
module hsr_line_fsm
    import hsr_pkg::*;
#(
    parameter int SUPP_PIX = 2,
    parameter int SHIFT_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_edge,
    input  logic               pix_evt,
    input  logic [SHIFT_W-1:0] fine_shift,
    output logic               capture
);
    localparam int SHIFT_MAX = (1 << SHIFT_W);
    localparam int EC_MAX    = (SUPP_PIX > SHIFT_MAX) ? SUPP_PIX : SHIFT_MAX;
    localparam int EC_W      = $clog2(EC_MAX + 1);

    line_state_t        state_q, state_d;
    logic [EC_W-1:0]    evt_q, evt_d;
    logic [SHIFT_W-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            evt_q   <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            evt_q   <= evt_d;
            if (sync_edge) shift_q <= fine_shift;
        end
    end

    always_comb begin
        state_d = state_q;
        evt_d   = evt_q;
        if (sync_edge) begin
            state_d = ST_HOLD;
            evt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_HOLD: begin
                    if (pix_evt) begin
                        if (evt_q == EC_W'(SUPP_PIX - 1)) begin
                            state_d = (shift_q == '0) ? ST_RUN : ST_SHIFT;
                            evt_d   = '0;
                        end else begin
                            evt_d = evt_q + EC_W'(1);
                        end
                    end
                end
                ST_SHIFT: begin
                    if (pix_evt) begin
                        if ((evt_q + EC_W'(1)) == EC_W'(shift_q)) begin
                            state_d = ST_RUN;
                            evt_d   = '0;
                        end else begin
                            evt_d = evt_q + EC_W'(1);
                        end
                    end
                end
                ST_RUN: ;
            endcase
        end
    end

    always_comb begin
        capture = (state_q == ST_RUN) && pix_evt;
    end

    // R4: every sync edge opens the suppression window
    a_r4_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
        sync_edge |=> (state_q == ST_HOLD));
    // R5: packing continues until the next sync edge
    a_r5_run_persist: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !sync_edge) |=> (state_q == ST_RUN));
endmodule

// File: rtl/hsr_pixel_packer.sv
module hsr_pixel_packer
    import hsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_edge,
    input  logic [1:0]       depth_sel,
    input  logic             capture,
    input  logic [BUS_W-1:0] pix_in,
    output logic [BUS_W-1:0] data_out,
    output logic             strobe
);
    logic [BUS_W-1:0] acc_q, merged;
    logic [BUS_W-1:0] data_q;
    logic [1:0]       slot_q;
    logic [1:0]       depth_q;
    logic             pend_q;
    logic             strobe_q;
    logic             word_done;

    always_comb begin
        merged = acc_q;
        if (depth_q == DEPTH_12) begin
            merged = pix_in;
        end else if (depth_q == DEPTH_6) begin
            if (slot_q[0]) merged[11:6] = pix_in[5:0];
            else           merged[5:0]  = pix_in[5:0];
        end else begin
            merged[3*int'(slot_q) +: 3] = pix_in[2:0];
        end
    end

    assign word_done = capture && (slot_q == last_slot(depth_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            data_q   <= '0;
            slot_q   <= '0;
            depth_q  <= '0;
            pend_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            pend_q <= word_done;
            if (pend_q) strobe_q <= ~strobe_q;
            if (sync_edge) begin
                acc_q   <= '0;
                slot_q  <= '0;
                depth_q <= depth_sel;
            end else if (word_done) begin
                data_q <= merged;
                acc_q  <= '0;
                slot_q <= '0;
            end else if (capture) begin
                acc_q  <= merged;
                slot_q <= slot_q + 2'd1;
            end
        end
    end

    assign data_out = data_q;
    assign strobe   = strobe_q;

    // R7: a strobe edge comes two clocks after a capture from the sequencer
    a_r7_strobe_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(strobe_q) |-> $past(capture, 2));
    // R7: the bus word only moves on a capture
    a_r7_data_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> $past(capture));
    // R6: slot index stays inside the word for the active depth
    a_r6_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= last_slot(depth_q));
endmodule

// File: rtl/hsync_strobe_regen.sv
module hsync_strobe_regen
    import hsr_pkg::*;
#(
    parameter int SUPP_PIX = 2,
    parameter int SHIFT_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hsync,
    input  logic               ratio_x8,
    input  logic               ofs_we,
    input  logic [CNT_W-1:0]   ofs_wdata,
    input  logic [1:0]         depth_sel,
    input  logic [SHIFT_W-1:0] fine_shift,
    input  logic [BUS_W-1:0]   pix_in,
    output logic               strobe,
    output logic [BUS_W-1:0]   data_out
);
    logic sync_edge;
    logic pix_evt;
    logic capture;

    hsr_phase_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync     (hsync),
        .ratio_x8  (ratio_x8),
        .ofs_we    (ofs_we),
        .ofs_wdata (ofs_wdata),
        .sync_edge (sync_edge),
        .pix_evt   (pix_evt)
    );

    hsr_line_fsm #(
        .SUPP_PIX (SUPP_PIX),
        .SHIFT_W  (SHIFT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_edge  (sync_edge),
        .pix_evt    (pix_evt),
        .fine_shift (fine_shift),
        .capture    (capture)
    );

    hsr_pixel_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_edge (sync_edge),
        .depth_sel (depth_sel),
        .capture   (capture),
        .pix_in    (pix_in),
        .data_out  (data_out),
        .strobe    (strobe)
    );

    // R1: strobe stays low until a sync edge has been seen
    logic seen_sync_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         seen_sync_q <= 1'b0;
        else if (sync_edge) seen_sync_q <= 1'b1;
    end
    a_r1_quiet_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_sync_q |-> (strobe == 1'b0));
endmodule

// File: tb/sim_hsync_strobe_regen.sv
module sim_hsync_strobe_regen;
    localparam int LINE = 60;
    localparam int SUPP = 2;

    typedef struct packed {
        logic       x8;
        logic [2:0] off;
        logic [1:0] dep;
        logic [1:0] sh;
        logic [7:0] first;
    } vec_t;

    // ratio, phase, depth, shift, expected first strobe cycle (255 = none)
    localparam vec_t VEC [8] = '{
        '{1'b0, 3'd0, 2'd0, 2'd0, 8'd14},
        '{1'b0, 3'd5, 2'd1, 2'd1, 8'd31},
        '{1'b1, 3'd3, 2'd2, 2'd0, 8'd45},
        '{1'b1, 3'd7, 2'd1, 2'd3, 8'd57},
        '{1'b0, 3'd2, 2'd2, 2'd2, 8'd46},
        '{1'b0, 3'd7, 2'd0, 2'd0, 8'd255},
        '{1'b1, 3'd0, 2'd1, 2'd0, 8'd26},
        '{1'b0, 3'd3, 2'd0, 2'd3, 8'd35}
    };

    logic        clk = 1'b0;
    logic        rst_n, hsync, ratio_x8, ofs_we;
    logic [2:0]  ofs_wdata;
    logic [1:0]  depth_sel, fine_shift;
    logic [11:0] pix_in;
    logic        strobe;
    logic [11:0] data_out;

    always #10 clk = ~clk;

    hsync_strobe_regen u0 (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .ratio_x8(ratio_x8),
        .ofs_we(ofs_we), .ofs_wdata(ofs_wdata), .depth_sel(depth_sel),
        .fine_shift(fine_shift), .pix_in(pix_in), .strobe(strobe), .data_out(data_out)
    );

    int checks = 0;
    int fails  = 0;
    int T      = 0;
    bit prev_s = 1'b0;
    bit pend_v = 1'b0;
    int pend_t = 0;
    logic [11:0] pend_w;
    logic [11:0] m_acc;
    int m_slot;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] pixf(input int t);
        return 12'((t * 613) ^ 32'hA5C);
    endfunction

    task automatic observe(output bit hit);
        hit = 1'b0;
        if (pend_v && T == pend_t - 1) begin
            chk(data_out == pend_w, "R7", "word ahead of strobe", int'(data_out), int'(pend_w));
            chk(strobe == prev_s, "R7", "strobe waits one clock", int'(strobe), int'(prev_s));
        end else if (pend_v && T == pend_t) begin
            chk(strobe != prev_s, "R7", "strobe edge", int'(strobe), int'(!prev_s));
            chk(data_out == pend_w, "R6 R8", "packed word", int'(data_out), int'(pend_w));
            pend_v = 1'b0;
            hit = 1'b1;
        end else begin
            chk(strobe == prev_s, "R7", "no stray strobe edge", int'(strobe), int'(prev_s));
        end
        prev_s = strobe;
    endtask

    task automatic run_line(input vec_t cur, input vec_t nxt);
        int n = cur.x8 ? 8 : 6;
        int e = 0;
        int first = -1;
        int fields = (cur.dep == 2'd0) ? 1 : (cur.dep == 2'd1) ? 2 : 4;
        bit hit;
        m_acc = '0;
        m_slot = 0;
        for (int t = 0; t < LINE; t++) begin
            @(negedge clk);
            T++;
            observe(hit);
            if (hit && first < 0 && t >= 2) first = t;
            pix_in = pixf(T);
            if (t != LINE - 1 && (t % n) == int'(cur.off)) begin
                if (e >= SUPP + int'(cur.sh)) begin
                    if (fields == 1)      m_acc = pix_in;
                    else if (fields == 2) m_acc[6*m_slot +: 6] = pix_in[5:0];
                    else                  m_acc[3*m_slot +: 3] = pix_in[2:0];
                    if (m_slot == fields - 1) begin
                        pend_v = 1'b1; pend_t = T + 2; pend_w = m_acc;
                        m_acc = '0; m_slot = 0;
                    end else begin
                        m_slot++;
                    end
                end
                e++;
            end
            if (t == 2) hsync = 1'b0;
            if (t == 4) begin
                ofs_we = 1'b1; ofs_wdata = nxt.off; ratio_x8 = nxt.x8;
                depth_sel = nxt.dep; fine_shift = nxt.sh;
            end
            if (t == 5) ofs_we = 1'b0;
            if (t == LINE - 1) hsync = 1'b1;
        end
        // R2 R4 R5: first strobe edge lands where counter, suppression and shift put it
        if (cur.first == 8'd255)
            chk(first == -1, "R3", "unmatched phase gives no strobe", first, -1);
        else
            chk(first == int'(cur.first), "R2 R4 R5", "first strobe cycle", first, int'(cur.first));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit hit;
        rst_n = 1'b0; hsync = 1'b0; ratio_x8 = 1'b0; ofs_we = 1'b0;
        ofs_wdata = '0; depth_sel = '0; fine_shift = '0; pix_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values and silence before any sync
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(strobe == 1'b0, "R1", "strobe idle after reset", int'(strobe), 0);
            chk(data_out == '0, "R1", "bus idle after reset", int'(data_out), 0);
            pix_in = pixf(i + 100);
        end
        // first line settings, then the first sync edge (R3: latched at sync)
        @(negedge clk);
        ofs_we = 1'b1; ofs_wdata = VEC[0].off; ratio_x8 = VEC[0].x8;
        depth_sel = VEC[0].dep; fine_shift = VEC[0].sh;
        @(negedge clk);
        ofs_we = 1'b0; hsync = 1'b1;
        for (int v = 0; v < 8; v++)
            run_line(VEC[v], VEC[(v < 7) ? v + 1 : 7]);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            T++;
            observe(hit);
            if (i == 0) hsync = 1'b0;
        end
        // R1: reset in mid-line clears outputs, no strobe without a new sync
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(strobe == 1'b0, "R1", "strobe cleared by reset", int'(strobe), 0);
        chk(data_out == '0, "R1", "bus cleared by reset", int'(data_out), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(strobe == 1'b0, "R1", "no strobe before sync", int'(strobe), 0);
            pix_in = pixf(i * 7);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule